// File: doc/BRIEF.md
# Bit-Addressable Boolean Processor

This unit carries out single-bit Boolean operations for a small controller core. A host presents an operation code and an 8-bit bit address. The unit works out which byte holds that bit and which position the bit occupies. It then either combines the bit with an internal carry flag, or rewrites the bit in place with a read-modify-write of its byte. Bytes live in an external synchronous byte memory, which holds internal RAM and the register latches. I/O port bits can also be sampled straight from a pin bus.

The lower half of the bit-address space covers a 16-byte RAM window. The upper half covers a parameterised list of special-function registers whose byte addresses are multiples of eight. The carry flag is kept inside the unit and drives an output. It is also reachable as a bit of the status register. Each operation is accepted while `ready` is high. Its result takes effect at the clock edge that ends the single-cycle `done` pulse.

Top module: `bitproc_core`

## Requirements
- R1: A bit address below 80h selects RAM byte 20h + addr[6:3] and bit position addr[2:0].
- R2: A bit address of 80h or above selects byte {addr[7:3],000} and position addr[2:0], provided that byte is in the register list. With default parameters the list is 80h, 88h, 90h, 98h, A0h, A8h, B0h, B8h, D0h, E0h and F0h.
- R3: Bit address D7h (bit 7 of the status byte at D0h) is the internal carry flag. Reads and writes to it act on `carry` and never reach the memory port.
- R4: Operation codes on `op_code`:
  - 0: AND the bit into the carry.
  - 1: AND the complemented bit into the carry.
  - 2: OR the bit into the carry.
  - 3: OR the complemented bit into the carry.
  - 4: copy the bit to the carry.
  - 5: copy the carry to the bit.
  - 6: set the carry. 7: clear the carry. 8: complement the carry.
  - 9: set the bit. Ah: clear the bit. Bh: complement the bit.
- R5: Codes 1 and 3 never modify the addressed bit: they issue no memory write.
- R6: A bit write reads the containing byte in one cycle and writes it back in the next, to the same address. Only the addressed bit may differ between the byte read and the byte written.
- R7: Codes 0 to 4 on a port byte take the bit from `pins` and do not read the latch. Port i (byte 80h, 90h, A0h, B0h for i = 0..3) is `pins[8i+7:8i]`. Codes 5 and 9 to Bh on a port byte read and write the latch in memory.
- R8: An upper-half address whose byte is not in the list reads as 0 and causes no memory access. `err` is high during that operation's `done` cycle.
- R9: `ready` is high only when idle. `done` rises two cycles after acceptance and lasts one cycle. Carry and memory updates occur at the edge that ends `done`.
- R10: Codes 6 to 8 touch no memory. No status bit other than the carry changes unless that bit is itself addressed.
- R11: After reset `carry` is 0, `ready` is 1, and `done`, `mem_re` and `mem_we` are 0.
- R12: Codes Ch to Fh complete with no effect on carry or memory, and with `err` low.
- R13: This sequence ends with carry 1:
  - set 00h; copy 00h to carry; copy carry to 7Fh;
  - AND-complement 00h, which gives 0;
  - OR 00h, which gives 1;
  - complement 7Fh;
  - clear carry;
  - OR-complement 7Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when `ready` is high |
| op_code | input | 4 | Operation code (R4) |
| op_addr | input | 8 | Bit address |
| ready | output | 1 | Idle, able to accept an operation |
| done | output | 1 | Operation completes this cycle |
| err | output | 1 | Unlisted register address, valid with `done` |
| carry | output | 1 | Carry flag |
| mem_addr | output | 8 | Byte address for the memory port |
| mem_re | output | 1 | Byte read, data expected on `mem_rdata` next cycle |
| mem_rdata | input | 8 | Read data |
| mem_we | output | 1 | Byte write |
| mem_wdata | output | 8 | Write data |
| pins | input | 32 | Port pin levels, 8 per port |

## Verification
The bench targets the corner cases where a byte-level shortcut would go wrong:
- **Port whose latch and pins disagree.** A design that read the latch for a source would copy 1 into the carry where the pins show 0. One that read the pins for a complement would write back the wrong byte.
- **Complemented AND/OR forms.** The bench confirms that no write is issued, so a design that stored the inverted operand would be caught.
- **The carry's own bit address.** Touching it must not disturb the other status bits held in memory.
- **Unlisted register bytes.** These must read as 0 and stay unwritten, with `err` raised.
- **The required sequence and neighbouring bits.** The required sequence is run, and neighbouring bits are checked so that a wrong bit-position merge is caught.

// File: rtl/bitproc_pkg.sv
// Shared types and operation classes for the bit-level Boolean unit.
// Assumes a 4-bit operation code; codes above CPLB are undefined no-ops.
package bitproc_pkg;

    typedef enum logic [3:0] {
        OP_ANDC  = 4'h0,
        OP_ANDNC = 4'h1,
        OP_ORC   = 4'h2,
        OP_ORNC  = 4'h3,
        OP_MOVCB = 4'h4,
        OP_MOVBC = 4'h5,
        OP_SETC  = 4'h6,
        OP_CLRC  = 4'h7,
        OP_CPLC  = 4'h8,
        OP_SETB  = 4'h9,
        OP_CLRB  = 4'hA,
        OP_CPLB  = 4'hB,
        OP_RSVC  = 4'hC,
        OP_RSVD  = 4'hD,
        OP_RSVE  = 4'hE,
        OP_RSVF  = 4'hF
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXEC = 2'd2
    } st_e;

    // Location of one bit after address decode.
    typedef struct packed {
        logic [7:0] byte_addr;
        logic [2:0] pos;
        logic       valid;
        logic       is_carry;
        logic       is_port;
    } bloc_t;

    // Operations that only read the addressed bit.
    function automatic logic op_src_only(input bop_e op);
        return (op == OP_ANDC) || (op == OP_ANDNC) || (op == OP_ORC) ||
               (op == OP_ORNC) || (op == OP_MOVCB);
    endfunction

    // Operations that rewrite the addressed bit.
    function automatic logic op_writes_bit(input bop_e op);
        return (op == OP_MOVBC) || (op == OP_SETB) || (op == OP_CLRB) ||
               (op == OP_CPLB);
    endfunction

    // Operations that use only the carry and ignore the address.
    function automatic logic op_carry_only(input bop_e op);
        return (op == OP_SETC) || (op == OP_CLRC) || (op == OP_CPLC);
    endfunction

endpackage

// File: rtl/bitproc_decode.sv
// Bit-address decoder: splits an 8-bit bit address into a byte address and
// bit position, checks the upper half against the register list, and flags
// port bytes and the carry bit.
// Assumes every port byte also appears in the register list.
module bitproc_decode
    import bitproc_pkg::*;
#(
    parameter int                        SFR_COUNT   = 11,
    parameter logic [SFR_COUNT*8-1:0]    SFR_LIST    = {8'h80, 8'h88, 8'h90, 8'h98,
                                                        8'hA0, 8'hA8, 8'hB0, 8'hB8,
                                                        8'hD0, 8'hE0, 8'hF0},
    parameter int                        PORT_COUNT  = 4,
    parameter logic [PORT_COUNT*8-1:0]   PORT_LIST   = {8'hB0, 8'hA0, 8'h90, 8'h80},
    parameter logic [7:0]                RAM_BASE    = 8'h20,
    parameter logic [7:0]                STATUS_ADDR = 8'hD0,
    parameter int                        CARRY_POS   = 7,
    parameter int                        PIDX_W      = 2
) (
    input  logic [7:0]        bit_addr,
    output bloc_t             loc,
    output logic [PIDX_W-1:0] port_idx
);

    localparam logic [7:0] CARRY_BIT = {STATUS_ADDR[7:3], 3'(CARRY_POS)};

    logic [SFR_COUNT-1:0]  sfr_hit;
    logic [PORT_COUNT-1:0] port_hit;

    // One comparator per listed register byte.
    for (genvar i = 0; i < SFR_COUNT; i++) begin : g_sfr
        assign sfr_hit[i] = (bit_addr[7:3] == SFR_LIST[i*8+3 +: 5]);
    end

    // One comparator per port byte.
    for (genvar j = 0; j < PORT_COUNT; j++) begin : g_port
        assign port_hit[j] = (bit_addr[7:3] == PORT_LIST[j*8+3 +: 5]);
    end

    // Encode the matching port into an index for the pin bus.
    always_comb begin
        port_idx = '0;
        for (int k = 0; k < PORT_COUNT; k++) begin
            if (port_hit[k]) port_idx = PIDX_W'(k);
        end
    end

    // Build the location record for either half of the address space.
    always_comb begin
        loc.pos = bit_addr[2:0];
        if (bit_addr[7]) begin
            loc.byte_addr = {bit_addr[7:3], 3'b000};
            loc.valid     = |sfr_hit;
        end else begin
            loc.byte_addr = RAM_BASE + {4'b0000, bit_addr[6:3]};
            loc.valid     = 1'b1;
        end
        loc.is_carry = (bit_addr == CARRY_BIT);
        loc.is_port  = bit_addr[7] && (|sfr_hit) && (|port_hit);
    end

endmodule

// File: rtl/bitproc_alu.sv
// Single-bit Boolean function unit: given the operation, the carry and the
// addressed bit, produces the next carry and next bit with their enables.
// Assumes the caller gates the enables with address validity.
module bitproc_alu
    import bitproc_pkg::*;
(
    input  bop_e op,
    input  logic carry_in,
    input  logic bit_in,
    output logic carry_out,
    output logic carry_we,
    output logic bit_out,
    output logic bit_we
);

    // Evaluate the operation table.
    always_comb begin
        carry_out = carry_in;
        carry_we  = 1'b0;
        bit_out   = bit_in;
        bit_we    = 1'b0;
        unique case (op)
            OP_ANDC:  begin carry_out = carry_in &  bit_in; carry_we = 1'b1; end
            OP_ANDNC: begin carry_out = carry_in & ~bit_in; carry_we = 1'b1; end
            OP_ORC:   begin carry_out = carry_in |  bit_in; carry_we = 1'b1; end
            OP_ORNC:  begin carry_out = carry_in | ~bit_in; carry_we = 1'b1; end
            OP_MOVCB: begin carry_out = bit_in;             carry_we = 1'b1; end
            OP_SETC:  begin carry_out = 1'b1;               carry_we = 1'b1; end
            OP_CLRC:  begin carry_out = 1'b0;               carry_we = 1'b1; end
            OP_CPLC:  begin carry_out = ~carry_in;          carry_we = 1'b1; end
            OP_MOVBC: begin bit_out = carry_in;             bit_we   = 1'b1; end
            OP_SETB:  begin bit_out = 1'b1;                 bit_we   = 1'b1; end
            OP_CLRB:  begin bit_out = 1'b0;                 bit_we   = 1'b1; end
            OP_CPLB:  begin bit_out = ~bit_in;              bit_we   = 1'b1; end
            default:  begin end
        endcase
    end

endmodule

// File: rtl/bitproc_merge.sv
// Byte merge: replaces one bit of a byte and keeps the other seven.
// Assumes pos selects the bit to replace.
module bitproc_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0]         byte_in,
    input  logic [$clog2(W)-1:0] pos,
    input  logic                 bit_val,
    output logic [W-1:0]         byte_out
);

    // One mux per bit lane.
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign byte_out[i] = (pos == ($clog2(W))'(i)) ? bit_val : byte_in[i];
    end

endmodule

// File: rtl/bitproc_core.sv
// Bit-level Boolean unit top: accepts an operation and a bit address,
// sequences IDLE -> READ -> EXEC, reads the containing byte from a
// synchronous memory (data one cycle after mem_re), and combines it with
// the internal carry or writes the modified byte back.
// Assumes the memory holds RAM and register latches at their byte addresses.
module bitproc_core
    import bitproc_pkg::*;
#(
    parameter int                        SFR_COUNT   = 11,
    parameter logic [SFR_COUNT*8-1:0]    SFR_LIST    = {8'h80, 8'h88, 8'h90, 8'h98,
                                                        8'hA0, 8'hA8, 8'hB0, 8'hB8,
                                                        8'hD0, 8'hE0, 8'hF0},
    parameter int                        PORT_COUNT  = 4,
    parameter logic [PORT_COUNT*8-1:0]   PORT_LIST   = {8'hB0, 8'hA0, 8'h90, 8'h80},
    parameter logic [7:0]                RAM_BASE    = 8'h20,
    parameter logic [7:0]                STATUS_ADDR = 8'hD0,
    parameter int                        CARRY_POS   = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic [3:0]              op_code,
    input  logic [7:0]              op_addr,
    output logic                    ready,
    output logic                    done,
    output logic                    err,
    output logic                    carry,
    output logic [7:0]              mem_addr,
    output logic                    mem_re,
    input  logic [7:0]              mem_rdata,
    output logic                    mem_we,
    output logic [7:0]              mem_wdata,
    input  logic [PORT_COUNT*8-1:0] pins
);

    localparam int PIDX_W = (PORT_COUNT > 1) ? $clog2(PORT_COUNT) : 1;

    st_e               state_q;
    bop_e              op_q;
    logic [7:0]        addr_q;
    logic              carry_q;
    bloc_t             loc;
    logic [PIDX_W-1:0] port_idx;
    logic [7:0]        pin_byte;
    logic              op_defined;
    logic              use_pins;
    logic              need_mem;
    logic              bit_src;
    logic              alu_c, alu_cwe, alu_b, alu_bwe;
    logic [7:0]        merged;

    // Address decode on the captured address.
    bitproc_decode #(
        .SFR_COUNT  (SFR_COUNT),
        .SFR_LIST   (SFR_LIST),
        .PORT_COUNT (PORT_COUNT),
        .PORT_LIST  (PORT_LIST),
        .RAM_BASE   (RAM_BASE),
        .STATUS_ADDR(STATUS_ADDR),
        .CARRY_POS  (CARRY_POS),
        .PIDX_W     (PIDX_W)
    ) u_dec (
        .bit_addr(addr_q),
        .loc     (loc),
        .port_idx(port_idx)
    );

    // Classify the captured operation and pick where its bit comes from.
    always_comb begin
        op_defined = op_src_only(op_q) || op_writes_bit(op_q) || op_carry_only(op_q);
        use_pins   = op_src_only(op_q) && loc.is_port;
        need_mem   = op_defined && !op_carry_only(op_q) && loc.valid &&
                     !loc.is_carry && !use_pins;
        pin_byte   = pins[int'(port_idx)*8 +: 8];
        if (loc.is_carry)   bit_src = carry_q;
        else if (!loc.valid) bit_src = 1'b0;
        else if (use_pins)  bit_src = pin_byte[loc.pos];
        else                bit_src = mem_rdata[loc.pos];
    end

    bitproc_alu u_alu (
        .op       (op_q),
        .carry_in (carry_q),
        .bit_in   (bit_src),
        .carry_out(alu_c),
        .carry_we (alu_cwe),
        .bit_out  (alu_b),
        .bit_we   (alu_bwe)
    );

    bitproc_merge #(.W(8)) u_merge (
        .byte_in (mem_rdata),
        .pos     (loc.pos),
        .bit_val (alu_b),
        .byte_out(merged)
    );

    // Sequencer and operation capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RSVF;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (op_valid) begin
                    op_q    <= bop_e'(op_code);
                    addr_q  <= op_addr;
                    state_q <= ST_READ;
                end
                ST_READ: state_q <= ST_EXEC;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Carry flag update at the end of the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (state_q == ST_EXEC) begin
            if (alu_cwe)                                   carry_q <= alu_c;
            else if (alu_bwe && loc.is_carry)               carry_q <= alu_b;
        end
    end

    // Output drive.
    always_comb begin
        ready     = (state_q == ST_IDLE);
        done      = (state_q == ST_EXEC);
        err       = done && op_defined && !op_carry_only(op_q) && !loc.valid;
        carry     = carry_q;
        mem_addr  = loc.byte_addr;
        mem_re    = (state_q == ST_READ) && need_mem;
        mem_we    = done && need_mem && alu_bwe;
        mem_wdata = merged;
    end

    // R6
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_re) && ($past(mem_addr) == mem_addr)));

    // R6
    one_bit_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    // R5
    cpl_src_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_ANDNC || op_q == OP_ORNC)) |-> !mem_we);

    // R8
    bad_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_we && !$past(mem_re)));

    // R9
    carry_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(carry) |-> $past(done));

    // R9
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, mem_re, done}));

endmodule

// File: tb/sim_bitproc_core.sv
module sim_bitproc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'h0;
    logic [7:0]  op_addr = 8'h00;
    logic        ready, done, err, carry;
    logic [7:0]  mem_addr, mem_wdata;
    logic        mem_re, mem_we;
    logic [7:0]  mem_rdata = 8'h00;
    logic [31:0] pins = 32'h0;

    logic [7:0]  mem [256];
    int          wr_count = 0;
    int          n_run = 0;
    int          n_fail = 0;
    logic        e;

    always #2.5 clk = ~clk;

    bitproc_core u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .ready(ready), .done(done), .err(err), .carry(carry),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .pins(pins)
    );

    // Synchronous byte memory model.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one operation and check its handshake timing (R9).
    task automatic run_op(input logic [3:0] op, input logic [7:0] a, output logic err_seen);
        @(negedge clk);
        chk(ready == 1'b1, "R9 ready idle", int'(ready), 1);
        op_valid = 1'b1; op_code = op; op_addr = a;
        @(negedge clk);
        op_valid = 1'b0;
        chk(done == 1'b0 && ready == 1'b0, "R9 busy", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R9 done", int'(done), 1);
        err_seen = err;
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(carry == 1'b0, "R11 carry", int'(carry), 0);
        chk(ready == 1'b1, "R11 ready", int'(ready), 1);
        chk(!done && !mem_re && !mem_we, "R11 strobes", int'({done, mem_re, mem_we}), 0);
    endtask

    task automatic t_sequence();
        run_op(4'h9, 8'h00, e);
        chk(mem[8'h20] == 8'h01, "R13 set 00h", mem[8'h20], 8'h01);
        run_op(4'h4, 8'h00, e);
        chk(carry == 1'b1, "R13 copy to carry", int'(carry), 1);
        run_op(4'h5, 8'h7F, e);
        chk(mem[8'h2F] == 8'h80, "R13 copy to 7Fh", mem[8'h2F], 8'h80);
        run_op(4'h1, 8'h00, e);
        chk(carry == 1'b0, "R13 and-not", int'(carry), 0);
        run_op(4'h2, 8'h00, e);
        chk(carry == 1'b1, "R13 or", int'(carry), 1);
        run_op(4'hB, 8'h7F, e);
        chk(mem[8'h2F] == 8'h00, "R13 cpl 7Fh", mem[8'h2F], 8'h00);
        run_op(4'h7, 8'h00, e);
        chk(carry == 1'b0, "R13 clr carry", int'(carry), 0);
        run_op(4'h3, 8'h7F, e);
        chk(carry == 1'b1, "R13 final carry", int'(carry), 1);
    endtask

    task automatic t_ram_map();
        mem[8'h2C] = 8'hA5; mem[8'h28] = 8'h0F; mem[8'h21] = 8'hFF;
        run_op(4'h9, 8'h63, e);
        chk(mem[8'h2C] == 8'hAD, "R1 R6 set 63h", mem[8'h2C], 8'hAD);
        run_op(4'hB, 8'h47, e);
        chk(mem[8'h28] == 8'h8F, "R1 R6 cpl 47h", mem[8'h28], 8'h8F);
        run_op(4'hA, 8'h0D, e);
        chk(mem[8'h21] == 8'hDF, "R1 R6 clr 0Dh", mem[8'h21], 8'hDF);
        run_op(4'h4, 8'h0D, e);
        chk(carry == 1'b0, "R1 R4 copy 0Dh", int'(carry), 0);
    endtask

    task automatic t_sfr();
        mem[8'hA8] = 8'h00; mem[8'hF0] = 8'h80; mem[8'hE0] = 8'hFF;
        run_op(4'h9, 8'hAA, e);
        chk(mem[8'hA8] == 8'h04, "R2 set AAh", mem[8'hA8], 8'h04);
        run_op(4'h6, 8'h00, e);
        run_op(4'h5, 8'hF1, e);
        chk(mem[8'hF0] == 8'h82, "R2 R4 carry to F1h", mem[8'hF0], 8'h82);
        run_op(4'hA, 8'hE7, e);
        chk(mem[8'hE0] == 8'h7F, "R2 clr E7h", mem[8'hE0], 8'h7F);
    endtask

    task automatic t_carry_bit();
        int w0;
        mem[8'hD0] = 8'h55;
        w0 = wr_count;
        run_op(4'h6, 8'h00, e);
        run_op(4'hA, 8'hD7, e);
        chk(carry == 1'b0, "R3 clr D7h", int'(carry), 0);
        run_op(4'h9, 8'hD7, e);
        chk(carry == 1'b1, "R3 set D7h", int'(carry), 1);
        run_op(4'h8, 8'h00, e);
        chk(carry == 1'b0, "R10 cpl carry", int'(carry), 0);
        chk(wr_count == w0 && mem[8'hD0] == 8'h55, "R3 R10 status untouched",
            mem[8'hD0], 8'h55);
        run_op(4'hB, 8'hD1, e);
        chk(mem[8'hD0] == 8'h57 && carry == 1'b0, "R10 other status bit",
            mem[8'hD0], 8'h57);
    endtask

    task automatic t_cpl_forms();
        int w0;
        mem[8'h24] = 8'h10;
        w0 = wr_count;
        run_op(4'h6, 8'h00, e);
        run_op(4'h1, 8'h24, e);
        chk(carry == 1'b0, "R4 and-not bit 24h", int'(carry), 0);
        run_op(4'h3, 8'h20, e);
        chk(carry == 1'b1, "R4 or-not bit 20h", int'(carry), 1);
        chk(wr_count == w0 && mem[8'h24] == 8'h10, "R5 no write",
            wr_count - w0, 0);
    endtask

    task automatic t_port();
        int w0;
        mem[8'h90] = 8'hFF;
        pins = 32'h0000_0000;
        w0 = wr_count;
        run_op(4'h6, 8'h00, e);
        run_op(4'h4, 8'h95, e);
        chk(carry == 1'b0, "R7 source from pins", int'(carry), 0);
        chk(wr_count == w0, "R7 source no write", wr_count - w0, 0);
        run_op(4'hB, 8'h95, e);
        chk(mem[8'h90] == 8'hDF, "R7 cpl uses latch", mem[8'h90], 8'hDF);
        pins = 32'h0000_2000;
        run_op(4'h4, 8'h95, e);
        chk(carry == 1'b1, "R7 pins over latch", int'(carry), 1);
        run_op(4'h5, 8'h93, e);
        chk(mem[8'h90] == 8'hDF, "R7 carry to latch bit", mem[8'h90], 8'hDF);
    endtask

    task automatic t_bad_addr();
        int w0;
        mem[8'hC8] = 8'h00;
        w0 = wr_count;
        run_op(4'h6, 8'h00, e);
        run_op(4'h0, 8'hC3, e);
        chk(e == 1'b1, "R8 err on source", int'(e), 1);
        chk(carry == 1'b0, "R8 reads zero", int'(carry), 0);
        run_op(4'h9, 8'hC8, e);
        chk(e == 1'b1, "R8 err on write", int'(e), 1);
        chk(wr_count == w0 && mem[8'hC8] == 8'h00, "R8 write ignored",
            mem[8'hC8], 8'h00);
        run_op(4'h9, 8'h21, e);
        chk(e == 1'b0, "R8 no err on RAM", int'(e), 0);
    endtask

    task automatic t_undefined();
        int w0;
        logic c0;
        w0 = wr_count;
        c0 = carry;
        run_op(4'hD, 8'h00, e);
        chk(carry == c0 && wr_count == w0, "R12 no effect", int'(carry), int'(c0));
        chk(e == 1'b0, "R12 no err", int'(e), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sequence();
        t_ram_map();
        t_sfr();
        t_carry_bit();
        t_cpl_forms();
        t_port();
        t_bad_addr();
        t_undefined();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule